// File: doc/BRIEF.md
# Plane Overflow Monitor with Deferred Darkness Decay

This block protects an 8-bit intensity plane of 256×256 cells from saturating. While a stamping engine writes updated cells back to plane memory, the block watches the write-back words. Each word holds eight cells. Every enabled cell byte is compared with one of two limits: 0xE0 or 0xF0, chosen by the host through a select bit. A byte strictly above the active limit raises a sticky flag.

The running operation is never interrupted. Once the stamping engine signals that its operation has finished, and the flag is set, the block takes over the plane memory port. It sweeps all 8192 words in ascending order, performing a read followed by a write for each one, and halves every cell with a one-bit logical right shift. When the sweep ends, the block pulses a completion output, drops the flag and sets a host-visible status bit. The host clears that bit by writing 1.

The controller is a five-state machine:
- `ST_IDLE` (no exceedance seen) moves to `ST_ARMED` on a hit. It moves straight to `ST_READ` when a hit and the operation-done strobe arrive in the same cycle.
- `ST_ARMED` (flag held) moves to `ST_READ` on the operation-done strobe.
- `ST_READ` (read request for the current word) always moves to `ST_WRITE`.
- `ST_WRITE` (halved word written back) returns to `ST_READ` for the next address, or goes to `ST_FINISH` after the last word.
- `ST_FINISH` (completion pulse) returns to `ST_IDLE`.

Top module: `ovf_decay_top`

## Requirements
- R1: After reset, busy, over_flag, decay_done, decay_seen and mem_req are all 0.
- R2: With thr_sel=0 the limit is 0xE0 and with thr_sel=1 it is 0xF0. Only a byte strictly greater than the limit counts as a hit, so a byte equal to the limit does not.
- R3: Only bytes whose snoop_be bit is 1, in a cycle with snoop_valid=1, are compared. Lane i is snoop_data bits [8i+7:8i] and is enabled by snoop_be[i].
- R4: over_flag is 1 from the cycle after the first hit until the sweep's completion cycle. Further hits in the meantime start no additional sweep.
- R5: A sweep starts in the cycle after op_done=1 is sampled with the flag set, or with a hit in that same cycle. op_done with no hit and no flag has no effect.
- R6: A sweep visits word addresses 0 to 8191 in ascending order. Each address gets a read cycle (mem_req=1, mem_we=0) and then a write cycle (mem_req=1, mem_we=1) to the same address. mem_rdata is taken one cycle after the read. The completion cycle follows 16384 cycles after the sweep starts.
- R7: In each write cycle, every byte of mem_wdata equals the matching byte of mem_rdata shifted right by one bit.
- R8: busy is 1 from the first read cycle through the completion cycle. Snoop hits and op_done during busy are ignored.
- R9: decay_done is a one-cycle pulse in the cycle after the last write. In the following cycle busy and over_flag are 0.
- R10: decay_seen becomes 1 in the cycle after decay_done. status_clr=1 clears it. If decay_done and status_clr coincide, decay_seen is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snoop_valid | input | 1 | A write-back word is present on snoop_data |
| snoop_data | input | 64 | Write-back word, eight cell bytes |
| snoop_be | input | 8 | Per-byte enables of the snooped word |
| thr_sel | input | 1 | Limit select: 0 gives 0xE0, 1 gives 0xF0 |
| op_done | input | 1 | Strobe marking the end of a stamping operation |
| status_clr | input | 1 | Write-1 clear of decay_seen |
| busy | output | 1 | Sweep in progress; no new stamping may start |
| over_flag | output | 1 | Sticky exceedance flag |
| decay_done | output | 1 | One-cycle sweep completion pulse |
| decay_seen | output | 1 | Host status: a sweep has occurred |
| mem_req | output | 1 | Plane memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 13 | Plane word address |
| mem_wdata | output | 64 | Halved write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read |

## Verification
The assertions check the following on every cycle:
- every read is followed by a write to the same address;
- each write is followed either by the read of the next address or by the completion pulse;
- written bytes never carry a set top bit;
- busy implies the flag;
- the flag stays up until completion;
- the completion pulse lasts one cycle and sets the status bit.

Only the bench's scenarios can show the rest:
- the limit comparison at exactly 0xE0 and 0xF0;
- lane masking;
- that a sweep waits for the operation-done strobe;
- that hits during a sweep are ignored;
- the exact sweep length;
- that every word of memory ends up halved;
- the priority of set over clear on the status bit.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } ovf_state_t;

    function automatic logic in_sweep(input ovf_state_t s);
        return (s == ST_READ) || (s == ST_WRITE) || (s == ST_FINISH);
    endfunction

endpackage

// File: rtl/ovf_thresh_cmp.sv
module ovf_thresh_cmp #(
    parameter int CELLS  = 8,
    parameter int CELL_W = 8
) (
    input  logic [CELLS*CELL_W-1:0] lane_data,
    input  logic [CELLS-1:0]        lane_en,
    input  logic [CELL_W-1:0]       limit,
    output logic                    any_over
);

    logic [CELLS-1:0] lane_hit;

    for (genvar g = 0; g < CELLS; g++) begin : g_lane
        assign lane_hit[g] = lane_en[g] && (lane_data[g*CELL_W +: CELL_W] > limit);
    end

    assign any_over = |lane_hit;

endmodule

// File: rtl/ovf_halver.sv
module ovf_halver #(
    parameter int CELLS  = 8,
    parameter int CELL_W = 8
) (
    input  logic [CELLS*CELL_W-1:0] word_in,
    output logic [CELLS*CELL_W-1:0] word_out
);

    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        assign word_out[g*CELL_W +: CELL_W] = {1'b0, word_in[g*CELL_W+1 +: CELL_W-1]};
    end

endmodule

// File: rtl/ovf_sweep_ctr.sv
module ovf_sweep_ctr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] count,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] LAST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_last = (count == LAST);

endmodule

// File: rtl/ovf_decay_top.sv
module ovf_decay_top
    import ovf_pkg::*;
#(
    parameter int CELLS    = 8,
    parameter int CELL_W   = 8,
    parameter int ADDR_W   = 13,
    parameter int THR_LOW  = 'hE0,
    parameter int THR_HIGH = 'hF0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snoop_valid,
    input  logic [CELLS*CELL_W-1:0] snoop_data,
    input  logic [CELLS-1:0]        snoop_be,
    input  logic                    thr_sel,
    input  logic                    op_done,
    input  logic                    status_clr,
    output logic                    busy,
    output logic                    over_flag,
    output logic                    decay_done,
    output logic                    decay_seen,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [CELLS*CELL_W-1:0] mem_wdata,
    input  logic [CELLS*CELL_W-1:0] mem_rdata
);

    localparam int                WORD_W = CELLS * CELL_W;
    localparam logic [CELL_W-1:0] LIM_LO = CELL_W'(THR_LOW);
    localparam logic [CELL_W-1:0] LIM_HI = CELL_W'(THR_HIGH);

    ovf_state_t        state_q, state_d;
    logic [CELL_W-1:0] limit;
    logic              lane_over;
    logic              snoop_hit;
    logic [ADDR_W-1:0] word_idx;
    logic              word_last;
    logic              ctr_clr;
    logic              ctr_inc;
    logic [WORD_W-1:0] halved;
    logic              seen_q;

    assign limit = thr_sel ? LIM_HI : LIM_LO;

    ovf_thresh_cmp #(.CELLS(CELLS), .CELL_W(CELL_W)) u_cmp (
        .lane_data (snoop_data),
        .lane_en   (snoop_be),
        .limit     (limit),
        .any_over  (lane_over)
    );

    assign snoop_hit = snoop_valid && lane_over;

    ovf_halver #(.CELLS(CELLS), .CELL_W(CELL_W)) u_half (
        .word_in  (mem_rdata),
        .word_out (halved)
    );

    assign ctr_clr = !in_sweep(state_q);
    assign ctr_inc = (state_q == ST_WRITE) && !word_last;

    ovf_sweep_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .count   (word_idx),
        .at_last (word_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (snoop_hit && op_done) begin
                    state_d = ST_READ;
                end else if (snoop_hit) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (op_done) begin
                    state_d = ST_READ;
                end
            end
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = word_last ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy       = 1'b0;
        over_flag  = 1'b0;
        decay_done = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED: begin
                over_flag = 1'b1;
            end
            ST_READ: begin
                busy      = 1'b1;
                over_flag = 1'b1;
                mem_req   = 1'b1;
            end
            ST_WRITE: begin
                busy      = 1'b1;
                over_flag = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
            end
            ST_FINISH: begin
                busy       = 1'b1;
                over_flag  = 1'b1;
                decay_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = word_idx;
    assign mem_wdata = halved;

    // Host status: set on completion, cleared by writing 1; set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (state_q == ST_FINISH) begin
            seen_q <= 1'b1;
        end else if (status_clr) begin
            seen_q <= 1'b0;
        end
    end

    assign decay_seen = seen_q;

endmodule

// File: rtl/ovf_decay_chk.sv
module ovf_decay_chk #(
    parameter int CELLS  = 8,
    parameter int CELL_W = 8,
    parameter int ADDR_W = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    over_flag,
    input logic                    decay_done,
    input logic                    decay_seen,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [CELLS*CELL_W-1:0] mem_wdata
);

    localparam int WORD_W = CELLS * CELL_W;

    function automatic logic [WORD_W-1:0] top_bits();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < CELLS; i++) begin
            m[i*CELL_W + CELL_W - 1] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [WORD_W-1:0] MSB_MASK = top_bits();

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we && mem_addr == $past(mem_addr))); // R6

    AST_WRITE_THEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> ((mem_req && !mem_we && mem_addr == $past(mem_addr) + 1'b1) || decay_done)); // R6

    AST_WDATA_HALVED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wdata & MSB_MASK) == '0)); // R7

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R8

    AST_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> over_flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (over_flag && !decay_done) |=> over_flag); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        decay_done |=> (!decay_done && !busy && !over_flag)); // R9

    AST_DONE_SETS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        decay_done |=> decay_seen); // R10

endmodule

bind ovf_decay_top ovf_decay_chk #(
    .CELLS  (CELLS),
    .CELL_W (CELL_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .over_flag  (over_flag),
    .decay_done (decay_done),
    .decay_seen (decay_seen),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/ovf_decay_top_tb.sv
module ovf_decay_top_tb;

    localparam int CELLS  = 8;
    localparam int CELL_W = 8;
    localparam int ADDR_W = 13;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int WORD_W = CELLS * CELL_W;
    localparam int SWEEP  = 2 * WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              snoop_valid = 1'b0;
    logic [WORD_W-1:0] snoop_data = '0;
    logic [CELLS-1:0]  snoop_be = '0;
    logic              thr_sel = 1'b0;
    logic              op_done = 1'b0;
    logic              status_clr = 1'b0;
    logic              busy, over_flag, decay_done, decay_seen;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  cmp_on   = 1'b0;
    bit  ended    = 1'b0;

    always #10 clk = ~clk;

    ovf_decay_top u_dut (
        .clk(clk), .rst_n(rst_n), .snoop_valid(snoop_valid), .snoop_data(snoop_data),
        .snoop_be(snoop_be), .thr_sel(thr_sel), .op_done(op_done), .status_clr(status_clr),
        .busy(busy), .over_flag(over_flag), .decay_done(decay_done), .decay_seen(decay_seen),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] init_word(input int a);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < CELLS; k++) begin
            w[k*CELL_W +: CELL_W] = CELL_W'((a * 7 + k * 29 + 3) & 255);
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] halve(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < CELLS; k++) begin
            r[k*CELL_W +: CELL_W] = w[k*CELL_W +: CELL_W] >> 1;
        end
        return r;
    endfunction

    // Plane memory behaviour
    logic [WORD_W-1:0] mem_model [int];

    function automatic logic [WORD_W-1:0] rd_word(input int a);
        if (mem_model.exists(a)) return mem_model[a];
        return init_word(a);
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= rd_word(int'(mem_addr));
        end
    end

    // Reference model: 0 idle, 1 armed, 2 read, 3 write, 4 finish
    int m_st  = 0;
    int m_cnt = 0;
    bit m_seen = 1'b0;

    function automatic bit model_hit();
        int lim;
        lim = thr_sel ? 'hF0 : 'hE0;
        if (!snoop_valid) return 1'b0;
        for (int k = 0; k < CELLS; k++) begin
            if (snoop_be[k] && int'(snoop_data[k*CELL_W +: CELL_W]) > lim) return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_seen <= 1'b0;
        end else begin
            case (m_st)
                0: if (model_hit() && op_done) begin m_st <= 2; m_cnt <= 0; end
                   else if (model_hit()) m_st <= 1;
                1: if (op_done) begin m_st <= 2; m_cnt <= 0; end
                2: m_st <= 3;
                3: if (m_cnt == WORDS - 1) m_st <= 4;
                   else begin m_cnt <= m_cnt + 1; m_st <= 2; end
                default: m_st <= 0;
            endcase
            if (m_st == 4) m_seen <= 1'b1;
            else if (status_clr) m_seen <= 1'b0;
        end
    end

    // Cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(busy == (m_st >= 2), "R8 busy", 64'(busy), 64'(m_st >= 2));
            chk(over_flag == (m_st >= 1), "R4 over_flag", 64'(over_flag), 64'(m_st >= 1));
            chk(decay_done == (m_st == 4), "R9 decay_done", 64'(decay_done), 64'(m_st == 4));
            chk(decay_seen == m_seen, "R10 decay_seen", 64'(decay_seen), 64'(m_seen));
            chk({mem_req, mem_we} == {m_st == 2 || m_st == 3, m_st == 3}, "R6 req/we",
                64'({mem_req, mem_we}), 64'({m_st == 2 || m_st == 3, m_st == 3}));
            if (m_st == 2 || m_st == 3)
                chk(int'(mem_addr) == m_cnt, "R6 mem_addr", 64'(mem_addr), 64'(m_cnt));
            if (m_st == 3)
                chk(mem_wdata == halve(rd_word(m_cnt)), "R7 mem_wdata", mem_wdata, halve(rd_word(m_cnt)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input bit v, input logic [WORD_W-1:0] d, input logic [CELLS-1:0] be,
                         input bit sel, input bit done);
        snoop_valid = v; snoop_data = d; snoop_be = be; thr_sel = sel; op_done = done;
    endtask

    task automatic idle_in();
        drive(1'b0, '0, '0, thr_sel, 1'b0);
    endtask

    task automatic pulse(input bit v, input logic [WORD_W-1:0] d, input logic [CELLS-1:0] be,
                         input bit sel, input bit done);
        drive(v, d, be, sel, done);
        tick(1);
        idle_in();
    endtask

    task automatic scan_mem(input int shifts, input string tag);
        int bad;
        logic [WORD_W-1:0] e;
        bad = 0;
        for (int a = 0; a < WORDS; a++) begin
            e = init_word(a);
            for (int s = 0; s < shifts; s++) e = halve(e);
            if (rd_word(a) != e) bad++;
        end
        chk(bad == 0, tag, 64'(bad), 64'(0));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        // R1 reset state
        chk({busy, over_flag, decay_done, decay_seen, mem_req} == 5'b0, "R1 reset outputs",
            64'({busy, over_flag, decay_done, decay_seen, mem_req}), 64'(0));
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick(2);

        // R2: equal to the low limit is not a hit
        pulse(1'b1, {8{8'hE0}}, 8'hFF, 1'b0, 1'b0);
        chk(over_flag == 1'b0, "R2 equal 0xE0", 64'(over_flag), 64'(0));
        // R2: equal to the high limit is not a hit
        pulse(1'b1, {8{8'hF0}}, 8'hFF, 1'b1, 1'b0);
        chk(over_flag == 1'b0, "R2 equal 0xF0", 64'(over_flag), 64'(0));
        // R2: above the low limit but below the high one, with the high one selected
        pulse(1'b1, {8{8'hE8}}, 8'hFF, 1'b1, 1'b0);
        chk(over_flag == 1'b0, "R2 high limit selected", 64'(over_flag), 64'(0));
        // R3: masked lane is ignored
        pulse(1'b1, 64'hFF << 24, 8'hF7, 1'b0, 1'b0);
        chk(over_flag == 1'b0, "R3 masked lane", 64'(over_flag), 64'(0));
        // R3: no valid, no hit
        pulse(1'b0, {8{8'hFF}}, 8'hFF, 1'b0, 1'b0);
        chk(over_flag == 1'b0, "R3 snoop_valid low", 64'(over_flag), 64'(0));
        // R5: op_done without a flag does nothing
        pulse(1'b0, '0, '0, 1'b0, 1'b1);
        chk(busy == 1'b0 && over_flag == 1'b0, "R5 done without flag", 64'({busy, over_flag}), 64'(0));
        // R2 R3: lane 6 just above 0xE0
        pulse(1'b1, 64'hE1 << 48, 8'h40, 1'b0, 1'b0);
        chk(over_flag == 1'b1, "R2 lane6 0xE1 hit", 64'(over_flag), 64'(1));
        // R4: another hit keeps one flag, no sweep yet
        pulse(1'b1, {8{8'hFF}}, 8'hFF, 1'b1, 1'b0);
        tick(5);
        chk(over_flag == 1'b1 && busy == 1'b0, "R5 sweep deferred", 64'({over_flag, busy}), 64'(2));

        // R5 R6: sweep starts after op_done
        pulse(1'b0, '0, '0, 1'b0, 1'b1);
        chk(busy && mem_req && !mem_we && mem_addr == '0, "R6 first read",
            64'({busy, mem_req, mem_we, mem_addr}), 64'({1'b1, 1'b1, 1'b0, 13'd0}));
        tick(99);
        // R8: hit and op_done during the sweep are ignored
        pulse(1'b1, {8{8'hFF}}, 8'hFF, 1'b0, 1'b1);
        tick(SWEEP + 1 - 101);
        chk(decay_done == 1'b1, "R6 R9 completion after sweep", 64'(decay_done), 64'(1));
        tick(1);
        chk(!busy && !over_flag && decay_seen, "R9 R10 after completion",
            64'({busy, over_flag, decay_seen}), 64'(1));
        tick(3);
        chk(!busy && !over_flag, "R4 R8 single sweep", 64'({busy, over_flag}), 64'(0));
        scan_mem(1, "R7 plane halved once");
        status_clr = 1'b1;
        tick(1);
        status_clr = 1'b0;
        chk(decay_seen == 1'b0, "R10 write-1 clear", 64'(decay_seen), 64'(1'b0));

        // R5: hit and op_done together start the sweep at once
        pulse(1'b1, 64'hF1, 8'h01, 1'b1, 1'b1);
        chk(busy == 1'b1 && mem_req == 1'b1, "R5 same-cycle start", 64'({busy, mem_req}), 64'(3));
        tick(SWEEP);
        chk(decay_done == 1'b1, "R9 second completion", 64'(decay_done), 64'(1));
        // R10: clear coinciding with completion loses to the set
        status_clr = 1'b1;
        tick(1);
        status_clr = 1'b0;
        chk(decay_seen == 1'b1, "R10 set wins over clear", 64'(decay_seen), 64'(1));
        scan_mem(2, "R7 plane halved twice");
        tick(2);
        finish_run();
    end

endmodule